// File: doc/BRIEF.md
# External Interrupt Request Detector

This block converts an active-low, asynchronous external interrupt pin into a latched request flag for an interrupt controller. The pin first passes through a synchronizer on the fast clock. A sample strobe pulses once per machine cycle of twelve clocks, and the synchronized pin is looked at only on those strobe edges. A mode input selects how a request is recognized. In level mode, every strobe that sees the pin low sets the flag. In falling-edge mode, the flag is set only when the strobe sees the pin low and the strobe before it saw the pin high.

The flag is a register. It is set on the same edge as the strobe that recognizes the request, so the controller can poll it during the next machine cycle. The controller clears it with a one-cycle strobe when it vectors to the matching service routine. Software can also write the flag directly. When updates collide, a hardware set wins over the clear strobe, and the clear strobe wins over a software write. Reset clears the flag and makes the stored previous sample read as high, which is the idle level of the pin.

Top module: `eirq_detector`

## Requirements
- R1: The pin is considered only at clock edges where `samp_stb` is 1. Between strobes, `req_flag` changes only through `vec_clr` or `sw_we`, so a low pulse that starts and ends between two strobes sets nothing.
- R2: With `edge_mode` = 0 (level), a strobe that samples the pin low (0) sets `req_flag` to 1. A strobe that samples it high (1) sets nothing.
- R3: With `edge_mode` = 1 (falling edge), a strobe sets `req_flag` only if it samples 0 and the previous strobe sampled 1. A pin held low over several strobes gives exactly one set.
- R4: `req_flag` is a registered output. It becomes 1 on the same clock edge as the strobe that recognizes the request, and it holds that value until it is cleared or written.
- R5: `vec_clr` = 1 clears `req_flag` at that clock edge, unless a set happens at the same edge.
- R6: In level mode, if the pin is still low after a clear, the next strobe raises `req_flag` again.
- R7: `sw_we` = 1 loads `sw_wdata` into `req_flag` at that clock edge, unless a set or a clear happens at the same edge.
- R8: When updates land on the same edge, the priority is: hardware set first, then `vec_clr`, then the software write.
- R9: While `rst` is 1, `req_flag` is 0 and the stored previous sample is 1. As a result, in falling-edge mode a pin found low at the first strobe after reset counts as an edge.
- R10: The pin passes through SYNC_STAGES flops (default 2), all reset to 1. A change driven before clock edge k is first seen by a strobe at edge k+SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| edge_mode | input | 1 | 0 = level mode, 1 = falling-edge mode |
| samp_stb | input | 1 | One-clock sample strobe, once per machine cycle |
| vec_clr | input | 1 | Clear strobe issued on vectoring |
| sw_we | input | 1 | Software write enable for the flag |
| sw_wdata | input | 1 | Software write value |
| req_flag | output | 1 | Registered interrupt request flag |

## Verification
The bench checks a pin held low across several strobes in edge mode. A detector that ignored the previous sample would set the flag again after each clear. It checks the same held-low pin in level mode, where a detector that latched only on edges would miss the request that should come back after a clear. Simultaneous set, clear and software-write cases check the priority order: a wrong order either drops a new request or lets a stale software write survive a vector. Further directed cases cover a low glitch between two strobes, which must not register. They also check the exact synchronizer delay, where a wrong stage count shifts the set by one edge, and the first edge after reset, which is lost if the previous sample resets low.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_mode_e;

  // Decide whether one strobe sample raises a request.
  function automatic logic trig_hit(trig_mode_e mode, logic prev_hi, logic cur_hi);
    logic hit;
    if (mode == TRIG_LEVEL) hit = !cur_hi;
    else                    hit = prev_hi && !cur_hi;
    return hit;
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= IDLE;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/eirq_sampler.sv
module eirq_sampler
  import eirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       samp_stb,
  input  trig_mode_e mode,
  input  logic       pin_smp,
  output logic       prev_smp,
  output logic       set_req
);

  // Previous strobe sample; reset to the idle-high level.
  always_ff @(posedge clk) begin
    if (rst)           prev_smp <= 1'b1;
    else if (samp_stb) prev_smp <= pin_smp;
  end

  always_comb begin
    set_req = samp_stb && trig_hit(mode, prev_smp, pin_smp);
  end

endmodule

// File: rtl/eirq_flag.sv
module eirq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic vec_clr,
  input  logic sw_we,
  input  logic sw_wdata,
  output logic flag
);

  // Priority: hardware set, then vector clear, then software write.
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
    else if (vec_clr) flag <= 1'b0;
    else if (sw_we)   flag <= sw_wdata;
  end

endmodule

// File: rtl/eirq_detector.sv
module eirq_detector
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic samp_stb,
  input  logic vec_clr,
  input  logic sw_we,
  input  logic sw_wdata,
  output logic req_flag
);

  logic       pin_smp;
  logic       prev_smp;
  logic       set_req;
  trig_mode_e mode;

  assign mode = trig_mode_e'(edge_mode);

  eirq_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_n),
    .q   (pin_smp)
  );

  eirq_sampler u_sampler (
    .clk      (clk),
    .rst      (rst),
    .samp_stb (samp_stb),
    .mode     (mode),
    .pin_smp  (pin_smp),
    .prev_smp (prev_smp),
    .set_req  (set_req)
  );

  eirq_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .set_req  (set_req),
    .vec_clr  (vec_clr),
    .sw_we    (sw_we),
    .sw_wdata (sw_wdata),
    .flag     (req_flag)
  );

endmodule

// File: rtl/eirq_detector_chk.sv
module eirq_detector_chk (
  input logic clk,
  input logic rst,
  input logic edge_mode,
  input logic samp_stb,
  input logic vec_clr,
  input logic sw_we,
  input logic sw_wdata,
  input logic req_flag,
  input logic pin_smp,
  input logic prev_smp
);

  // R1: no strobe, no clear, no write -> flag holds
  assert_hold_between_strobes_R1: assert property (@(posedge clk) disable iff (rst)
    (!samp_stb && !vec_clr && !sw_we) |=> $stable(req_flag));

  // R2: level mode, low sample -> flag set
  assert_level_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (samp_stb && !edge_mode && !pin_smp) |=> req_flag);

  // R3: edge mode with previous sample low -> no set
  assert_no_edge_no_set_R3: assert property (@(posedge clk) disable iff (rst)
    (samp_stb && edge_mode && !prev_smp && !vec_clr && !sw_we) |=> $stable(req_flag));

  // R5: clear without strobe -> flag low
  assert_vector_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (vec_clr && !samp_stb) |=> !req_flag);

  // R7: lone software write loads the value
  assert_sw_write_R7: assert property (@(posedge clk) disable iff (rst)
    (sw_we && !vec_clr && !samp_stb) |=> (req_flag == $past(sw_wdata)));

  // R9: reset state
  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!req_flag && prev_smp));

endmodule

bind eirq_detector eirq_detector_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .edge_mode (edge_mode),
  .samp_stb  (samp_stb),
  .vec_clr   (vec_clr),
  .sw_we     (sw_we),
  .sw_wdata  (sw_wdata),
  .req_flag  (req_flag),
  .pin_smp   (pin_smp),
  .prev_smp  (prev_smp)
);

// File: tb/tb_eirq_detector.sv
module tb_eirq_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_n = 1'b1;
  logic edge_mode = 1'b0;
  logic samp_stb = 1'b0;
  logic vec_clr = 1'b0;
  logic sw_we = 1'b0;
  logic sw_wdata = 1'b0;
  logic req_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eirq_detector dut (
    .clk(clk), .rst(rst), .pin_n(pin_n), .edge_mode(edge_mode),
    .samp_stb(samp_stb), .vec_clr(vec_clr), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .req_flag(req_flag)
  );

  // Bits: [6] pin, [5] mode, [4] stb, [3] clr, [2] we, [1] wdata, [0] expected flag
  localparam int NV = 17;
  localparam logic [6:0] VEC [NV] = '{
    7'b1010000, 7'b0010001, 7'b1001000, 7'b0010001, 7'b0001000,
    7'b0110000, 7'b1110000, 7'b0100000, 7'b0110001, 7'b0101000,
    7'b0110000, 7'b1100111, 7'b1100100, 7'b1110000, 7'b0110101,
    7'b0011001, 7'b1001110
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:    return "R2";
      2:       return "R5";
      3:       return "R6";
      4, 9:    return "R5";
      5, 10:   return "R3";
      6, 8:    return "R3";
      7:       return "R1";
      11, 12:  return "R7";
      13:      return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic exp);
    checks++;
    if (req_flag !== exp) begin
      errors++;
      $display("FAIL %s: req_flag=%b expected=%b at %0t", tag, req_flag, exp, $time);
    end
  endtask

  // Drive pin/mode, let the synchronizer settle, then one cycle of controls.
  task automatic step(logic p, logic m, logic s, logic c, logic w, logic wd);
    @(negedge clk);
    pin_n = p; edge_mode = m; samp_stb = 0; vec_clr = 0; sw_we = 0; sw_wdata = 0;
    repeat (3) @(negedge clk);
    samp_stb = s; vec_clr = c; sw_we = w; sw_wdata = wd;
    @(negedge clk);
    samp_stb = 0; vec_clr = 0; sw_we = 0; sw_wdata = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset flag", 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      check(tag_of(i), VEC[i][0]);
    end

    // R1: low glitch between strobes in edge mode is missed
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R1 idle high sample", 1'b0);
    @(negedge clk); pin_n = 1'b0;
    repeat (4) @(negedge clk);
    pin_n = 1'b1;
    repeat (3) @(negedge clk);
    samp_stb = 1'b1;
    @(negedge clk);
    samp_stb = 1'b0;
    check("R1 glitch missed", 1'b0);

    // R10/R4: level mode, pin and strobe change together
    edge_mode = 1'b0;
    pin_n = 1'b0; samp_stb = 1'b1;
    @(negedge clk);
    check("R10 edge k", 1'b0);
    @(negedge clk);
    check("R10 edge k+1", 1'b0);
    @(negedge clk);
    check("R10 R4 edge k+2", 1'b1);
    samp_stb = 1'b0;

    // R9: previous sample resets high, so held-low pin counts as an edge
    edge_mode = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R9 flag cleared", 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9 first edge after reset", 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule